// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the control logic that sits in front of the switch core of a 7-bit digital step attenuator with a 0.25 dB step. It produces a registered 7-bit attenuation state, and each set bit switches in one binary-weighted section. A host programs that state in one of three ways. The first is a serial word shifted in on a shift clock. The second is a parallel word captured by a pulse on the latch enable. The third is a parallel word passed straight through while the latch enable stays high.

Every control input is treated as asynchronous to the system clock. Each one passes through a two-stage synchroniser, and the shift clock is edge-detected on the system clock. After reset the output sits at maximum attenuation while a power-up delay counter runs for a set number of cycles. Until that delay has expired, latch requests are ignored. After it expires, the state register loads whenever the synchronised latch enable is high. The mode select input chooses whether the load comes from the serial shift register or from the parallel pins.

Top module: `atten_ctrl`

## Requirements
- R1: `ser_mode` low selects the parallel pins as the load source, and `ser_mode` high selects the serial shift register.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into an 8-bit register, least significant bit first, so the last bit shifted in ends up in bit 7.
- R3: In serial mode the shift register reaches `att_state` only while `latch_en` is high. Shifting while `latch_en` is low leaves `att_state` unchanged.
- R4: Bit 7 of the serial word has no effect. `att_state` takes bits 6..0, where bit 0 is 0.25 dB, bit 1 is 0.5 dB, bit 2 is 1 dB, bit 3 is 2 dB, bit 4 is 4 dB, bit 5 is 8 dB and bit 6 is 16 dB.
- R5: In latched-parallel use, changes on `par_in` while `latch_en` is low do not reach `att_state`. A high-then-low pulse on `latch_en` captures the value present at the end of the pulse.
- R6: In direct-parallel use, with `latch_en` held high, `att_state` follows `par_in` three system clock cycles after each change.
- R7: While `rst_n` is low, `att_state` is 7'h7F and `pwr_done` is 0.
- R8: In serial and latched-parallel use, `att_state` stays at 7'h7F after the delay expires, until a word is latched.
- R9: `pwr_done` rises `PWR_DLY_CYC`+1 cycles after reset is released and then stays high. Before that, `att_state` is 7'h7F and latch pulses are ignored. When `latch_en` is held high, the state then takes the value on `par_in`.
- R10: Changing `ser_mode` while `latch_en` is low does not alter `att_state`. The new source is used at the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-up |
| ser_mode | input | 1 | Load source: 0 parallel pins, 1 serial register |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_clk | input | 1 | Shift clock, sampled for rising edges |
| latch_en | input | 1 | Latch enable, transparent while high |
| par_in | input | 7 | Parallel attenuation word |
| att_state | output | 7 | Registered attenuation state to the switch core |
| pwr_done | output | 1 | Power-up delay expired |

## Verification
The assertions assume that each control input, once it has passed its synchroniser, is steady for at least one system cycle around every `ser_clk` edge. They also assume that serial data does not change in the cycle where a shift edge is detected. The stimulus holds every level of `ser_clk` and every `ser_data` bit for three system cycles, and it changes the mode and the parallel pins only with several idle cycles before any latch edge. This keeps every sampled value unambiguous, so the expected state can be computed without knowing synchroniser phase.

// File: rtl/atten_pkg.sv
// Package: shared widths, constants and types for the attenuator control block.
// Assumes a 7-bit attenuation word and an 8-bit serial frame whose top bit is unused.
package atten_pkg;
    localparam int ATT_W  = 7;
    localparam int SR_W   = ATT_W + 1;
    localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

    typedef logic [ATT_W-1:0] att_word_t;
    typedef logic [SR_W-1:0]  ser_word_t;
endpackage

// File: rtl/atten_sync.sv
// Module: multi-bit level synchroniser built from a chain of flops per bit.
// Assumes each bit is independent; it does not keep a multi-bit word coherent.
module atten_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_async;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage resamples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/atten_shreg.sv
// Module: serial-in, parallel-out shift register advanced on a detected shift-clock rise.
// Assumes sclk_s and sdata_s come from synchronisers of equal depth.
module atten_shreg
    import atten_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_s,
    input  logic      sdata_s,
    output ser_word_t word_q
);
    logic sclk_d;
    logic shift_rise;

    // Remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign shift_rise = sclk_s & ~sclk_d;

    // Shift toward bit 0 so the first bit in ends up at bit 0 after a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          word_q <= '0;
        else if (shift_rise) word_q <= {sdata_s, word_q[SR_W-1:1]};
    end
endmodule

// File: rtl/atten_pwrup.sv
// Module: power-up delay counter that raises a sticky done flag.
// Assumes DLY_CYC is at least 1; the counter saturates once done.
module atten_pwrup #(
    parameter int DLY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_q
);
    localparam int CW = $clog2(DLY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY_CYC);

    logic [CW-1:0] cnt_q;

    // Count system cycles since reset, stopping at the delay limit.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    // Raise done once the limit is reached, and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             done_q <= 1'b0;
        else if (cnt_q == LAST) done_q <= 1'b1;
    end
endmodule

// File: rtl/atten_state.sv
// Module: attenuation state register, transparent to the selected source while the latch is open.
// Assumes all inputs are already synchronous to clk.
module atten_state
    import atten_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ready,
    input  logic      le_s,
    input  logic      mode_s,
    input  att_word_t ser_word,
    input  att_word_t par_word,
    output att_word_t state_q
);
    att_word_t src;

    // Pick the load source from the mode select.
    always_comb begin
        src = mode_s ? ser_word : par_word;
    end

    // Hold maximum attenuation until ready, then follow the source while the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)              state_q <= ATT_MAX;
        else if (ready && le_s)  state_q <= src;
    end
endmodule

// File: rtl/atten_ctrl.sv
// Module: top of the step attenuator control interface.
// Synchronises the asynchronous controls, shifts serial data, times power-up and drives the state.
// Assumes the system clock is several times faster than the shift clock.
module atten_ctrl
    import atten_pkg::*;
#(
    parameter int PWR_DLY_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_mode,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic             latch_en,
    input  logic [ATT_W-1:0] par_in,
    output logic [ATT_W-1:0] att_state,
    output logic             pwr_done
);
    logic [3:0] ctl_s;
    logic       sclk_s, sdata_s, le_s, mode_s;
    att_word_t  par_s;
    ser_word_t  sreg_q;

    atten_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_mode, latch_en, ser_data, ser_clk}),
        .q_sync  (ctl_s)
    );

    assign sclk_s  = ctl_s[0];
    assign sdata_s = ctl_s[1];
    assign le_s    = ctl_s[2];
    assign mode_s  = ctl_s[3];

    atten_sync #(.W(ATT_W), .STAGES(SYNC_STAGES)) u_sync_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (par_in),
        .q_sync  (par_s)
    );

    atten_shreg u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdata_s (sdata_s),
        .word_q  (sreg_q)
    );

    atten_pwrup #(.DLY_CYC(PWR_DLY_CYC)) u_pwrup (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_q (pwr_done)
    );

    atten_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (pwr_done),
        .le_s     (le_s),
        .mode_s   (mode_s),
        .ser_word (sreg_q[ATT_W-1:0]),
        .par_word (par_s),
        .state_q  (att_state)
    );
endmodule

// File: rtl/atten_ctrl_chk.sv
// Module: assertion checker for atten_ctrl, attached with bind.
// Assumes it sees the synchronised latch and mode levels and the shift register from the top.
module atten_ctrl_chk #(
    parameter int W = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         le_s,
    input logic         mode_s,
    input logic [W-1:0] par_s,
    input logic [W-1:0] sreg_lo,
    input logic [W-1:0] att_state,
    input logic         pwr_done
);
    AST_PWRUP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_done |-> (att_state == {W{1'b1}})); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_done |=> pwr_done); // R9

    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !le_s |=> $stable(att_state)); // R3

    AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_done && le_s && mode_s) |=> (att_state == $past(sreg_lo))); // R1

    AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_done && le_s && !mode_s) |=> (att_state == $past(par_s))); // R6
endmodule

bind atten_ctrl atten_ctrl_chk #(.W(atten_pkg::ATT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .le_s      (le_s),
    .mode_s    (mode_s),
    .par_s     (par_s),
    .sreg_lo   (sreg_q[atten_pkg::ATT_W-1:0]),
    .att_state (att_state),
    .pwr_done  (pwr_done)
);

// File: tb/atten_ctrl_tb_top.sv
module atten_ctrl_tb_top;
    localparam int DLY = 24;

    logic       clk = 1'b0;
    logic       rst_n, ser_mode, ser_data, ser_clk, latch_en;
    logic [6:0] par_in;
    logic [6:0] att_state;
    logic       pwr_done;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    atten_ctrl #(.PWR_DLY_CYC(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ser_data(ser_data),
        .ser_clk(ser_clk), .latch_en(latch_en), .par_in(par_in),
        .att_state(att_state), .pwr_done(pwr_done)
    );

    // {is_serial, word, expected state}
    localparam logic [15:0] VECS [0:8] = '{
        {1'b1, 8'h32, 7'h32},
        {1'b1, 8'hB2, 7'h32},
        {1'b1, 8'h01, 7'h01},
        {1'b1, 8'h40, 7'h40},
        {1'b1, 8'h80, 7'h00},
        {1'b0, 8'h55, 7'h55},
        {1'b0, 8'h00, 7'h00},
        {1'b0, 8'h7F, 7'h7F},
        {1'b1, 8'h2A, 7'h2A}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(3);
        ser_clk = 1'b0;
    endtask

    task automatic shift_word(input logic [7:0] w);
        for (int i = 0; i < 8; i++) shift_bit(w[i]);
        wait_clk(3);
    endtask

    task automatic pulse_le();
        latch_en = 1'b1;
        wait_clk(4);
        latch_en = 1'b0;
        wait_clk(6);
    endtask

    task automatic do_reset(input logic le_lvl);
        rst_n = 1'b0;
        latch_en = le_lvl;
        wait_clk(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        ser_mode = 1'b0; ser_data = 1'b0; ser_clk = 1'b0; par_in = 7'h15;
        do_reset(1'b1);
        check("R7 reset state", {1'b0, att_state}, 8'h7F);
        check("R7 reset done", {7'b0, pwr_done}, 8'h00);
        rst_n = 1'b1;
        wait_clk(8);
        check("R9 held max during delay", {1'b0, att_state}, 8'h7F);
        check("R9 done low during delay", {7'b0, pwr_done}, 8'h00);
        wait_clk(DLY + 6);
        check("R9 done after delay", {7'b0, pwr_done}, 8'h01);
        check("R9 direct takes pins after delay", {1'b0, att_state}, 8'h15);

        // Direct-parallel tracking
        par_in = 7'h2A; wait_clk(3);
        check("R6 direct follow 3 cycles", {1'b0, att_state}, 8'h2A);
        par_in = 7'h00; wait_clk(3);
        check("R6 direct follow zero", {1'b0, att_state}, 8'h00);
        latch_en = 1'b0; wait_clk(6);

        // Vector table: serial and latched-parallel loads
        for (int v = 0; v < 9; v++) begin
            if (VECS[v][15]) begin
                ser_mode = 1'b1; par_in = 7'h00; wait_clk(4);
                shift_word(VECS[v][14:7]);
                pulse_le();
                check("R2 R4 serial load", {1'b0, att_state}, {1'b0, VECS[v][6:0]});
            end else begin
                ser_mode = 1'b0; par_in = VECS[v][13:7]; wait_clk(4);
                pulse_le();
                check("R5 latched parallel load", {1'b0, att_state}, {1'b0, VECS[v][6:0]});
                par_in = ~VECS[v][13:7]; wait_clk(8);
                check("R5 pins ignored while closed", {1'b0, att_state}, {1'b0, VECS[v][6:0]});
            end
        end

        // Mid-shift: output must not move while closed (state is 2A)
        ser_mode = 1'b1; wait_clk(4);
        for (int i = 0; i < 4; i++) shift_bit(i[0]);
        wait_clk(3);
        check("R3 unchanged mid-shift", {1'b0, att_state}, 8'h2A);
        for (int i = 4; i < 8; i++) shift_bit(1'b1);
        wait_clk(3);
        check("R3 unchanged after full shift", {1'b0, att_state}, 8'h2A);
        pulse_le();
        check("R3 serial transfer on latch", {1'b0, att_state}, 8'h7A);

        // Mode change while closed takes effect at next latch
        ser_mode = 1'b0; par_in = 7'h11; wait_clk(8);
        check("R10 mode change closed no effect", {1'b0, att_state}, 8'h7A);
        pulse_le();
        check("R1 parallel source after latch", {1'b0, att_state}, 8'h11);
        ser_mode = 1'b1; wait_clk(8);
        check("R10 back to serial closed no effect", {1'b0, att_state}, 8'h11);
        pulse_le();
        check("R1 serial source after latch", {1'b0, att_state}, 8'h7A);

        // Latched-parallel power-up: early latch ignored, max kept until latch
        ser_mode = 1'b0; par_in = 7'h0F;
        do_reset(1'b0);
        rst_n = 1'b1;
        wait_clk(3);
        pulse_le();
        check("R9 latch during delay ignored", {1'b0, att_state}, 8'h7F);
        wait_clk(DLY + 6);
        check("R8 max kept after delay", {1'b0, att_state}, 8'h7F);
        check("R9 done sticky", {7'b0, pwr_done}, 8'h01);
        pulse_le();
        check("R8 first latch after delay", {1'b0, att_state}, 8'h0F);

        // Serial power-up default
        ser_mode = 1'b1;
        do_reset(1'b0);
        rst_n = 1'b1;
        wait_clk(DLY + 8);
        check("R8 serial max kept after delay", {1'b0, att_state}, 8'h7F);
        shift_word(8'h05);
        check("R8 serial max kept while shifting", {1'b0, att_state}, 8'h7F);
        pulse_le();
        check("R2 serial after power-up", {1'b0, att_state}, 8'h05);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule